// File: doc/BRIEF.md
# Multi-Mode Multiply-Accumulate Datapath

This block multiplies two 32-bit source values and folds the product into a 48-bit accumulator. Each operation can add or subtract. A 2-bit arithmetic mode picks signed integer, unsigned integer or signed fractional arithmetic. For word-size operations, one select bit per operand picks the upper or lower halfword of its source, and that halfword is widened to 32 bits. The 64-bit product can be scaled by one bit position in either direction before it is summed. In fractional mode the scale request is ignored.

The exact sum of the accumulator and the scaled product is checked against the 48-bit range of the active mode. A result that does not fit raises a sticky overflow flag. When saturation is enabled, an overflowing result is clamped to the nearest representable extreme. While saturation is enabled and the flag is already set, every further operation leaves the accumulator untouched.

Operations are issued with a single-cycle start strobe. The block reports busy while it works and gives a one-cycle done pulse once the result has settled.

Top module: `mac_unit`

## Requirements
- R1: After a synchronous reset the accumulator reads zero, the overflow flag is low, and both busy and done are low.
- R2: A start sampled while idle captures all operands and controls at that clock edge. The accumulator takes its new value at the second following edge, and done is high for exactly the one cycle after the third edge. Busy is high from the first edge to the third. A start seen while busy is ignored.
- R3: With long_op=1 the whole 32-bit source is the operand. In mode 00 (signed integer) the product is the two's-complement product of the two operands.
- R4: With long_op=0, sel_hi=1 takes source bits [31:16] and sel_hi=0 takes bits [15:0]. The halfword is sign-extended in modes 00, 10 and 11, and zero-extended in mode 01.
- R5: In mode 01 (unsigned integer) the operands, the product and the accumulator are all treated as unsigned numbers.
- R6: Scale code 01 shifts the 64-bit product left by one and puts a zero in the lsb. Code 10 shifts it right by one. Codes 00 and 11 leave it unshifted. An unsigned right shift brings in a zero at the msb.
- R7: A signed right shift brings in the product's sign bit at the msb. It brings in a zero instead when the product is zero, or when the operation is longword and the unshifted product lies outside the 48-bit signed range.
- R8: In modes 10 and 11 (signed fractional) the scale code has no effect.
- R9: cmd_sub=0 adds the scaled product to the accumulator, and cmd_sub=1 subtracts it.
- R10: An executed operation whose exact sum falls outside the 48-bit range sets the overflow flag, which stays set until reset. The range is signed in modes 00, 10 and 11 and unsigned in mode 01. Without saturation the accumulator keeps the low 48 bits of the sum.
- R11: With sat_en=1, an overflowing sum clamps the accumulator. In the signed modes it goes to 0x7FFF_FFFF_FFFF for a positive sum and 0x8000_0000_0000 for a negative one. In unsigned mode it goes to all ones above the range and to zero below it.
- R12: With sat_en=1 and the overflow flag already set, an operation leaves the accumulator and the flag unchanged, and done still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue strobe, taken only when idle |
| cmd_sub | input | 1 | 1 subtracts the product, 0 adds it |
| mode | input | 2 | 00 signed int, 01 unsigned int, 1x signed fractional |
| long_op | input | 1 | 1 uses full 32-bit operands, 0 uses halfwords |
| sel_hi_x | input | 1 | Halfword select for src_x (1 = upper) |
| sel_hi_y | input | 1 | Halfword select for src_y (1 = upper) |
| scale | input | 2 | 00/11 none, 01 left by one, 10 right by one |
| sat_en | input | 1 | Saturation enable |
| src_x | input | 32 | First source value |
| src_y | input | 32 | Second source value |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 48 | Accumulator contents |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The bench builds the block with its default widths: 32-bit sources and a 48-bit accumulator. With these widths a single longword product can already exceed the accumulator. That lets a single operation reach the clamp to either extreme, the zero-fill right shift on an out-of-range longword product, and the skip once the flag is pending, without long accumulation chains. Halfword operations stay far inside the range, so they isolate extension, select and shift effects from overflow.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CALC = 2'b01,
    ST_FIN  = 2'b10
  } mac_state_e;

  localparam logic [1:0] MODE_SINT  = 2'b00;
  localparam logic [1:0] MODE_UINT  = 2'b01;
  localparam logic [1:0] SCL_LEFT   = 2'b01;
  localparam logic [1:0] SCL_RIGHT  = 2'b10;

  typedef struct packed {
    logic is_signed;
    logic is_frac;
  } arith_t;

  function automatic arith_t decode_mode(logic [1:0] m);
    arith_t a;
    a.is_signed = (m != MODE_UINT);
    a.is_frac   = m[1];
    return a;
  endfunction

endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic              long_op,
  input  logic              sel_hi,
  input  logic              sext,
  output logic [DATA_W-1:0] opnd
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] widen_half(logic [HALF_W-1:0] h, logic s);
    return {{HALF_W{s & h[HALF_W-1]}}, h};
  endfunction

  logic [HALF_W-1:0] half_pick;

  assign half_pick = sel_hi ? src[DATA_W-1:HALF_W] : src[HALF_W-1:0];
  assign opnd      = long_op ? src : widen_half(half_pick, sext);

endmodule

// File: rtl/mac_product_scaler.sv
module mac_product_scaler
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic [DATA_W-1:0]   opnd_x,
  input  logic [DATA_W-1:0]   opnd_y,
  input  logic                is_signed,
  input  logic                is_frac,
  input  logic                long_op,
  input  logic [1:0]          scale,
  output logic [2*DATA_W-1:0] prod_scaled,
  output logic                raw_ovf,
  output logic                shift_used
);
  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [PROD_W-1:0] mul_full(logic [DATA_W-1:0] a,
                                                 logic [DATA_W-1:0] b,
                                                 logic s);
    logic [PROD_W-1:0] ea;
    logic [PROD_W-1:0] eb;
    ea = {{DATA_W{s & a[DATA_W-1]}}, a};
    eb = {{DATA_W{s & b[DATA_W-1]}}, b};
    return ea * eb;
  endfunction

  function automatic logic out_of_acc(logic [PROD_W-1:0] p, logic s);
    if (s) return p[PROD_W-1:ACC_W-1] != {(PROD_W-ACC_W+1){p[PROD_W-1]}};
    else   return p[PROD_W-1:ACC_W] != '0;
  endfunction

  function automatic logic [PROD_W-1:0] shift_prod(logic [PROD_W-1:0] p,
                                                   logic [1:0] code,
                                                   logic fill);
    if (code == SCL_LEFT)       return {p[PROD_W-2:0], 1'b0};
    else if (code == SCL_RIGHT) return {fill, p[PROD_W-1:1]};
    else                        return p;
  endfunction

  logic [PROD_W-1:0] raw_prod;
  logic              prod_zero;
  logic              msb_fill;

  assign raw_prod    = mul_full(opnd_x, opnd_y, is_signed);
  assign prod_zero   = (raw_prod == '0);
  assign raw_ovf     = out_of_acc(raw_prod, is_signed);
  assign msb_fill    = is_signed & raw_prod[PROD_W-1] & ~prod_zero & ~(long_op & raw_ovf);
  assign shift_used  = ~is_frac & ((scale == SCL_LEFT) | (scale == SCL_RIGHT));
  assign prod_scaled = shift_used ? shift_prod(raw_prod, scale, msb_fill) : raw_prod;

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int PROD_W = 64,
  parameter int ACC_W  = 48
) (
  input  logic [ACC_W-1:0]  acc_q,
  input  logic [PROD_W-1:0] prod,
  input  logic              is_signed,
  input  logic              subtract,
  input  logic              sat_en,
  output logic [ACC_W-1:0]  acc_next,
  output logic              ovf_evt
);
  localparam int WIDE_W = PROD_W + 2;

  function automatic logic [WIDE_W-1:0] ext_acc(logic [ACC_W-1:0] a, logic s);
    return {{(WIDE_W-ACC_W){s & a[ACC_W-1]}}, a};
  endfunction

  function automatic logic [WIDE_W-1:0] ext_prod(logic [PROD_W-1:0] p, logic s);
    return {{(WIDE_W-PROD_W){s & p[PROD_W-1]}}, p};
  endfunction

  function automatic logic fits(logic [WIDE_W-1:0] w, logic s);
    if (s) return w[WIDE_W-1:ACC_W-1] == {(WIDE_W-ACC_W+1){w[WIDE_W-1]}};
    else   return w[WIDE_W-1:ACC_W] == '0;
  endfunction

  function automatic logic [ACC_W-1:0] clamp_val(logic neg, logic s);
    if (s) return neg ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else   return neg ? '0 : '1;
  endfunction

  logic [WIDE_W-1:0] wide_sum;

  assign wide_sum = subtract ? ext_acc(acc_q, is_signed) - ext_prod(prod, is_signed)
                             : ext_acc(acc_q, is_signed) + ext_prod(prod, is_signed);
  assign ovf_evt  = ~fits(wide_sum, is_signed);
  assign acc_next = (ovf_evt & sat_en) ? clamp_val(wide_sum[WIDE_W-1], is_signed)
                                       : wide_sum[ACC_W-1:0];

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmd_sub,
  input  logic [1:0]        mode,
  input  logic              long_op,
  input  logic              sel_hi_x,
  input  logic              sel_hi_y,
  input  logic [1:0]        scale,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] src_x,
  input  logic [DATA_W-1:0] src_y,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  acc_out,
  output logic              ovf_flag
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int N_OPND = 2;

  mac_state_e        state;
  logic [DATA_W-1:0] x_q, y_q;
  logic              long_q, selx_q, sely_q, sub_q, sat_q;
  logic [1:0]        mode_q, scale_q;
  logic [ACC_W-1:0]  acc_q;
  logic              ovf_q;
  logic              done_q;
  arith_t            arith;

  // named internal events
  logic              acc_step;
  logic              skip_op;
  logic              clamp_hit;
  logic              frac_q;
  logic              shift_used;
  logic              raw_ovf;
  logic              ovf_evt;

  logic [DATA_W-1:0] src_arr  [N_OPND];
  logic              sel_arr  [N_OPND];
  logic [DATA_W-1:0] opnd_arr [N_OPND];
  logic [PROD_W-1:0] prod_scaled;
  logic [ACC_W-1:0]  acc_next;

  assign arith      = decode_mode(mode_q);
  assign frac_q     = arith.is_frac;
  assign src_arr[0] = x_q;
  assign src_arr[1] = y_q;
  assign sel_arr[0] = selx_q;
  assign sel_arr[1] = sely_q;

  for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
    mac_operand_sel #(.DATA_W(DATA_W)) u_sel (
      .src     (src_arr[i]),
      .long_op (long_q),
      .sel_hi  (sel_arr[i]),
      .sext    (arith.is_signed),
      .opnd    (opnd_arr[i])
    );
  end

  mac_product_scaler #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_scale (
    .opnd_x      (opnd_arr[0]),
    .opnd_y      (opnd_arr[1]),
    .is_signed   (arith.is_signed),
    .is_frac     (arith.is_frac),
    .long_op     (long_q),
    .scale       (scale_q),
    .prod_scaled (prod_scaled),
    .raw_ovf     (raw_ovf),
    .shift_used  (shift_used)
  );

  mac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .acc_q     (acc_q),
    .prod      (prod_scaled),
    .is_signed (arith.is_signed),
    .subtract  (sub_q),
    .sat_en    (sat_q),
    .acc_next  (acc_next),
    .ovf_evt   (ovf_evt)
  );

  assign acc_step  = (state == ST_CALC);
  assign skip_op   = acc_step & sat_q & ovf_q;
  assign clamp_hit = acc_step & ~skip_op & sat_q & ovf_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      long_q  <= 1'b0;
      selx_q  <= 1'b0;
      sely_q  <= 1'b0;
      sub_q   <= 1'b0;
      sat_q   <= 1'b0;
      mode_q  <= MODE_SINT;
      scale_q <= '0;
      acc_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state == ST_FIN);
      unique case (state)
        ST_IDLE: if (start) begin
          x_q     <= src_x;
          y_q     <= src_y;
          long_q  <= long_op;
          selx_q  <= sel_hi_x;
          sely_q  <= sel_hi_y;
          sub_q   <= cmd_sub;
          sat_q   <= sat_en;
          mode_q  <= mode;
          scale_q <= scale;
          state   <= ST_CALC;
        end
        ST_CALC: begin
          if (!skip_op) begin
            acc_q <= acc_next;
            if (ovf_evt) ovf_q <= 1'b1;
          end
          state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign acc_out  = acc_q;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf_flag,
  input logic             acc_step,
  input logic             skip_op,
  input logic             clamp_hit,
  input logic             frac_q,
  input logic             shift_used
);
  localparam logic [ACC_W-1:0] S_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] S_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // R2
  issue_to_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2
  step_to_done_chk: assert property (@(posedge clk) disable iff (rst)
    acc_step |=> (!done && busy) ##1 (done && !busy));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R12
  skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    skip_op |=> $stable(acc_out));

  // R11
  clamp_extreme_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_hit |=> (acc_out == S_MAX || acc_out == S_MIN ||
                   acc_out == '0 || acc_out == '1) && ovf_flag);

  // R8
  frac_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_step && frac_q) |-> !shift_used);

endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .acc_out    (acc_out),
  .ovf_flag   (ovf_flag),
  .acc_step   (acc_step),
  .skip_op    (skip_op),
  .clamp_hit  (clamp_hit),
  .frac_q     (frac_q),
  .shift_used (shift_used)
);

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst, start, cmd_sub, long_op, sel_hi_x, sel_hi_y, sat_en;
  logic [1:0]  mode, scale;
  logic [31:0] src_x, src_y;
  logic        busy, done, ovf_flag;
  logic [47:0] acc_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [47:0] m_acc;
  logic        m_ovf;

  always #4 clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_sub(cmd_sub), .mode(mode),
    .long_op(long_op), .sel_hi_x(sel_hi_x), .sel_hi_y(sel_hi_y), .scale(scale),
    .sat_en(sat_en), .src_x(src_x), .src_y(src_y), .busy(busy), .done(done),
    .acc_out(acc_out), .ovf_flag(ovf_flag)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic signed [127:0] pick(logic [31:0] r, bit lng, bit hi, bit sgn);
    logic [15:0] h;
    if (lng) return {{96{sgn & r[31]}}, r};
    h = hi ? r[31:16] : r[15:0];
    return {{112{sgn & h[15]}}, h};
  endfunction

  // independent reference: exact integers, then range tests
  task automatic model(bit sub, logic [1:0] md, bit lng, bit hx, bit hy,
                       logic [1:0] sc, bit sat, logic [31:0] x, logic [31:0] y);
    logic signed [127:0] p, p2, a, s, t;
    logic [63:0] t64;
    bit sgn, big;
    logic signed [127:0] smax, smin, umax;
    sgn  = (md != 2'b01);
    smax = (128'sd1 <<< 47) - 1;
    smin = -(128'sd1 <<< 47);
    umax = (128'sd1 <<< 48) - 1;
    if (sat && m_ovf) return;
    p  = pick(x, lng, hx, sgn) * pick(y, lng, hy, sgn);
    p2 = p;
    if (!md[1] && sc == 2'b01) begin
      t = p <<< 1; t64 = t[63:0];
      p2 = sgn ? {{64{t64[63]}}, t64} : {64'b0, t64};
    end else if (!md[1] && sc == 2'b10) begin
      big = (p > smax) || (p < smin);
      if (sgn && p < 0 && !(lng && big)) p2 = p >>> 1;
      else p2 = {65'b0, p[63:1]};
    end
    a = sgn ? {{80{m_acc[47]}}, m_acc} : {80'b0, m_acc};
    s = sub ? a - p2 : a + p2;
    if (sgn ? (s > smax || s < smin) : (s < 0 || s > umax)) begin
      m_ovf = 1'b1;
      if (sat) m_acc = sgn ? (s < 0 ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF)
                           : (s < 0 ? 48'h0 : 48'hFFFF_FFFF_FFFF);
      else m_acc = s[47:0];
    end else m_acc = s[47:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; start = 0; cmd_sub = 0; mode = 0; long_op = 0; sel_hi_x = 0;
    sel_hi_y = 0; scale = 0; sat_en = 0; src_x = 0; src_y = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_acc = '0; m_ovf = 0;
  endtask

  // issue one operation and check timing plus result (R2 timing each time)
  task automatic op(string req, bit sub, logic [1:0] md, bit lng, bit hx, bit hy,
                    logic [1:0] sc, bit sat, logic [31:0] x, logic [31:0] y);
    start = 1; cmd_sub = sub; mode = md; long_op = lng; sel_hi_x = hx;
    sel_hi_y = hy; scale = sc; sat_en = sat; src_x = x; src_y = y;
    @(negedge clk);
    start = 0;
    src_x = ~x; src_y = ~y; cmd_sub = ~sub;
    if (busy !== 1'b1 || done !== 1'b0) chk("R2 busy after issue", {busy, done}, 2'b10);
    @(negedge clk);
    model(sub, md, lng, hx, hy, sc, sat, x, y);
    chk({req, " acc"}, acc_out, m_acc);
    chk({req, " flag"}, ovf_flag, m_ovf);
    if (done !== 1'b0) chk("R2 done early", done, 0);
    @(negedge clk);
    if (done !== 1'b1 || busy !== 1'b0) chk("R2 done pulse", {busy, done}, 2'b01);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 acc", acc_out, 0);
    chk("R1 flags", {ovf_flag, busy, done}, 3'b000);
  endtask

  task automatic t_timing();
    do_reset();
    start = 1; mode = 0; long_op = 1; src_x = 5; src_y = 6;
    @(negedge clk);
    chk("R2 busy", busy, 1);
    @(negedge clk);           // start still high while busy
    start = 0;
    chk("R2 acc at second edge", acc_out, 48'd30);
    chk("R2 done low", done, 0);
    @(negedge clk);
    chk("R2 done high", {done, busy}, 2'b10);
    @(negedge clk);
    chk("R2 done one cycle", {done, busy}, 2'b00);
    chk("R2 repeated start ignored", acc_out, 48'd30);
  endtask

  task automatic t_signed_long();
    do_reset();
    op("R3 7*-3", 0, 2'b00, 1, 0, 0, 2'b00, 0, 32'd7, 32'hFFFF_FFFD);
    chk("R3 literal", acc_out, 48'hFFFF_FFFF_FFEB);
    op("R3 mixed", 0, 2'b00, 1, 0, 0, 2'b00, 0, 32'h0012_3456, 32'hFFFF_9ABC);
    op("R3 minus ones", 0, 2'b00, 1, 0, 0, 2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_word_sel();
    do_reset();
    op("R4 hi-lo", 0, 2'b00, 0, 1, 0, 2'b00, 0, 32'h0003_FFFE, 32'h0005_0002);
    chk("R4 literal 6", acc_out, 48'd6);
    op("R4 lo-hi sext", 0, 2'b00, 0, 0, 1, 2'b00, 0, 32'h0003_FFFE, 32'h0005_0002);
    chk("R4 literal -4", acc_out, 48'hFFFF_FFFF_FFFC);
    op("R4 hi-hi frac", 0, 2'b10, 0, 1, 1, 2'b00, 0, 32'h8000_0001, 32'h7FFF_0000);
  endtask

  task automatic t_unsigned();
    do_reset();
    op("R5 word zext", 0, 2'b01, 0, 0, 0, 2'b00, 0, 32'h0000_FFFE, 32'h0000_0002);
    chk("R5 literal", acc_out, 48'd131068);
    op("R5 long", 0, 2'b01, 1, 0, 0, 2'b00, 0, 32'h0000_FFFF, 32'h8000_0000);
  endtask

  task automatic t_scale();
    do_reset();
    op("R6 left signed", 0, 2'b00, 0, 0, 0, 2'b01, 0, 32'h0000_0009, 32'h0000_FFFF);
    chk("R6 literal -18", acc_out, 48'hFFFF_FFFF_FFEE);
    op("R6 code 11 none", 0, 2'b00, 0, 0, 0, 2'b11, 0, 32'h0000_0003, 32'h0000_0005);
    do_reset();
    op("R6 right unsigned", 0, 2'b01, 0, 0, 0, 2'b10, 0, 32'h0000_FFFF, 32'h0000_0003);
    chk("R6 literal", acc_out, 48'd98302);
    op("R6 left unsigned", 0, 2'b01, 1, 0, 0, 2'b01, 0, 32'h0001_0000, 32'h0000_0007);
  endtask

  task automatic t_right_fill();
    do_reset();
    op("R7 sign fill", 0, 2'b00, 0, 0, 0, 2'b10, 0, 32'h0000_FFFD, 32'h0000_0001);
    chk("R7 literal -2", acc_out, 48'hFFFF_FFFF_FFFE);
    chk("R7 no overflow", ovf_flag, 0);
    op("R7 zero product", 0, 2'b00, 0, 0, 0, 2'b10, 0, 32'h0000_8000, 32'h0);
    do_reset();
    op("R7 long out-of-range zero fill", 0, 2'b00, 1, 0, 0, 2'b10, 1,
       32'h4000_0000, 32'hC000_0000);
    chk("R7 clamp positive", acc_out, 48'h7FFF_FFFF_FFFF);
  endtask

  task automatic t_frac();
    do_reset();
    op("R8 frac left ignored", 0, 2'b10, 0, 0, 0, 2'b01, 0, 32'h0000_0003, 32'h0000_0007);
    chk("R8 literal 21", acc_out, 48'd21);
    op("R8 frac right ignored", 0, 2'b11, 0, 0, 0, 2'b10, 0, 32'h0000_FFFF, 32'h0000_0005);
    chk("R8 literal 16", acc_out, 48'd16);
  endtask

  task automatic t_sub();
    do_reset();
    op("R9 add", 0, 2'b00, 0, 0, 0, 2'b00, 0, 32'd100, 32'd3);
    op("R9 sub", 1, 2'b00, 0, 0, 0, 2'b00, 0, 32'd50, 32'd7);
    chk("R9 literal -50", acc_out, 48'hFFFF_FFFF_FFCE);
  endtask

  task automatic t_wrap();
    do_reset();
    op("R10 unsigned borrow", 1, 2'b01, 0, 0, 0, 2'b00, 0, 32'd1, 32'd1);
    chk("R10 wrap", acc_out, 48'hFFFF_FFFF_FFFF);
    chk("R10 flag set", ovf_flag, 1);
    op("R10 flag sticky", 0, 2'b01, 0, 0, 0, 2'b00, 0, 32'd1, 32'd1);
    chk("R10 flag still", ovf_flag, 1);
  endtask

  task automatic t_clamp();
    do_reset();
    op("R11 signed max", 0, 2'b00, 1, 0, 0, 2'b00, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R11 max", acc_out, 48'h7FFF_FFFF_FFFF);
    do_reset();
    op("R11 signed min", 0, 2'b00, 1, 0, 0, 2'b00, 1, 32'h7FFF_FFFF, 32'h8000_0000);
    chk("R11 min", acc_out, 48'h8000_0000_0000);
    do_reset();
    op("R11 unsigned low", 1, 2'b01, 0, 0, 0, 2'b00, 1, 32'd2, 32'd2);
    chk("R11 zero", acc_out, 48'h0);
  endtask

  task automatic t_skip();
    do_reset();
    op("R12 prime", 0, 2'b00, 1, 0, 0, 2'b00, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    op("R12 skipped", 1, 2'b00, 0, 0, 0, 2'b00, 1, 32'd5, 32'd5);
    chk("R12 held", acc_out, 48'h7FFF_FFFF_FFFF);
    chk("R12 flag kept", ovf_flag, 1);
    op("R12 no sat runs", 1, 2'b00, 0, 0, 0, 2'b00, 0, 32'd5, 32'd5);
    chk("R12 runs without sat", acc_out, 48'h7FFF_FFFF_FFE6);
  endtask

  initial begin
    rst = 1; start = 0;
    t_reset();
    t_timing();
    t_signed_long();
    t_word_sel();
    t_unsigned();
    t_scale();
    t_right_fill();
    t_frac();
    t_sub();
    t_wrap();
    t_clamp();
    t_skip();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule